// File: doc/BRIEF.md
# Reconfiguration Port Master

This block drives the reconfiguration port of a clock synthesizer on behalf of a simple user request interface. The port lives entirely in one clock domain and consists of an enable strobe, a write-enable, an address, a 16-bit write bus, a 16-bit read bus and a ready response from the slave. The master issues one transaction at a time. It pulses the enable for a single cycle and then waits for ready. It captures read data on the edge where ready is seen and reports completion to the user with a one-cycle done pulse.

Each user request carries an address, write data, a mask and two flags: write and read-modify-write. A read-modify-write request first reads the addressed word. It then writes back `(old & ~mask) | (new & mask)` and reports a single done pulse at the end. While a transaction is outstanding the master reports busy. Requests made during that time are dropped and tallied in a saturating counter. A watchdog ends any transaction whose ready never comes and flags the abort as a timeout.

Top module: `reconf_port_master`

## Requirements
- R1: After a synchronous reset the outputs are all low or zero: enable, busy, done, timeout, rdata and the rejected-request counter.
- R2: An accepted request drives enable high for exactly one cycle, in the cycle after the accepting edge, with address, write-enable and write data valid in that same cycle. No new enable is issued while a transaction waits for ready.
- R3: A read (write flag 0, modify flag 0) drives write-enable low. Read data is captured on the edge where ready is high. The done pulse lasts one cycle and starts the cycle after that edge. rdata keeps the captured value until another read completes.
- R4: A write (write flag 1, modify flag 0) drives write-enable high and puts the request data on the write bus. It completes with done on the cycle after ready.
- R5: A read-modify-write does a read, then a second one-cycle enable with write-enable high and data `(old & ~mask) | (new & mask)`. It produces one done pulse, after the write's ready, and rdata holds the old value.
- R6: busy is high from the cycle after acceptance until the done cycle, and it is low in the done cycle. A request is accepted only while busy is low.
- R7: A request made while busy is high is ignored and adds one to the rejected-request counter, which saturates at its all-ones value.
- R8: If ready is not seen on any of the 256 edges following an enable cycle, the transaction is abandoned. done and timeout pulse together, busy falls, and a late ready has no effect.
- R9: The read and write data paths are 16 bits wide, and all-ones values pass through unchanged.
- R10: When both the write flag and the modify flag are set, the request is performed as a read-modify-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rmw | input | 1 | 1 = read-modify-write (overrides req_write) |
| req_addr | input | AW (7) | Target register address |
| req_wdata | input | DW (16) | Write data, or new bits for a modify request |
| req_mask | input | DW (16) | Bits taken from req_wdata in a modify request |
| busy | output | 1 | Transaction outstanding |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Pulses with done when the watchdog aborted |
| rdata | output | DW (16) | Last captured read value |
| err_count | output | ECW (8) | Saturating count of rejected requests |
| cfg_en | output | 1 | Port enable strobe |
| cfg_we | output | 1 | Port write-enable |
| cfg_addr | output | AW (7) | Port address |
| cfg_wdata | output | DW (16) | Port write data |
| cfg_rdata | input | DW (16) | Port read data |
| cfg_ready | input | 1 | Port completion response |

## Verification
Completion and request rejection can fall in the same cycle. When ready arrives, busy is still high at that edge. A request presented then is therefore dropped and counted, and only the next edge can accept it. The bench provokes this by holding req_valid high through several back-to-back transactions. It also holds req_valid high across most of a watchdog wait to push the counter into saturation. A behavioural model predicts every busy, done, enable and counter value each cycle, and the outputs are compared against it.

// File: rtl/reconf_pkg.sv
`timescale 1ns/1ps
package reconf_pkg;
  localparam int DATA_W = 16;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_t;
endpackage

// File: rtl/reconf_watchdog.sv
`timescale 1ns/1ps
module reconf_watchdog #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LAST);

  // the count only reaches its end by running
  assert_expiry_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
    (expired && !$past(expired)) |-> $past(run));
endmodule

// File: rtl/reconf_merge.sv
`timescale 1ns/1ps
module reconf_merge #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] new_val,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] merged
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign merged[i] = mask[i] ? new_val[i] : old_val[i];
  end
endmodule

// File: rtl/reconf_seq.sv
`timescale 1ns/1ps
module reconf_seq
  import reconf_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_rmw,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_mask,
  input  logic          prdy,
  input  logic [DW-1:0] prdata,
  input  logic [DW-1:0] merged,
  input  logic          expired,
  output logic          pe,
  output logic          pwe,
  output logic [AW-1:0] paddr,
  output logic [DW-1:0] pwdata,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] new_q,
  output logic [DW-1:0] mask_q,
  output logic          wd_clear,
  output logic          wd_run
);
  phase_t phase;
  logic   rmw_pend;
  logic   plain_wr;

  assign plain_wr = req_write && !req_rmw;
  assign wd_clear = ((phase == PH_IDLE) && req_valid) ||
                    ((phase == PH_RD) && prdy && rmw_pend);
  assign wd_run   = (phase != PH_IDLE) && !prdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      pe       <= 1'b0;
      pwe      <= 1'b0;
      paddr    <= '0;
      pwdata   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      rdata    <= '0;
      rmw_pend <= 1'b0;
      new_q    <= '0;
      mask_q   <= '0;
    end else begin
      pe      <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            pe       <= 1'b1;
            pwe      <= plain_wr;
            paddr    <= req_addr;
            pwdata   <= req_wdata;
            busy     <= 1'b1;
            rmw_pend <= req_rmw;
            new_q    <= req_wdata;
            mask_q   <= req_mask;
            phase    <= plain_wr ? PH_WR : PH_RD;
          end
        end
        PH_RD: begin
          if (prdy) begin
            rdata <= prdata;
            if (rmw_pend) begin
              pe       <= 1'b1;
              pwe      <= 1'b1;
              pwdata   <= merged;
              rmw_pend <= 1'b0;
              phase    <= PH_WR;
            end else begin
              done  <= 1'b1;
              busy  <= 1'b0;
              phase <= PH_IDLE;
            end
          end else if (expired) begin
            done     <= 1'b1;
            timeout  <= 1'b1;
            busy     <= 1'b0;
            rmw_pend <= 1'b0;
            phase    <= PH_IDLE;
          end
        end
        PH_WR: begin
          if (prdy) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            phase <= PH_IDLE;
          end else if (expired) begin
            done    <= 1'b1;
            timeout <= 1'b1;
            busy    <= 1'b0;
            phase   <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_en_single_R2: assert property (@(posedge clk) disable iff (rst)
    pe |=> !pe);
  assert_no_en_while_waiting_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !pe && !prdy) |=> !pe);
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && req_valid) |=> (pe && busy));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_timeout_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    timeout |-> done);
endmodule

// File: rtl/reconf_port_master.sv
`timescale 1ns/1ps
module reconf_port_master #(
  parameter int AW    = 7,
  parameter int DW    = reconf_pkg::DATA_W,
  parameter int ECW   = 8,
  parameter int LIMIT = 256
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic           req_rmw,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [DW-1:0]  req_mask,
  output logic           busy,
  output logic           done,
  output logic           timeout,
  output logic [DW-1:0]  rdata,
  output logic [ECW-1:0] err_count,
  output logic           cfg_en,
  output logic           cfg_we,
  output logic [AW-1:0]  cfg_addr,
  output logic [DW-1:0]  cfg_wdata,
  input  logic [DW-1:0]  cfg_rdata,
  input  logic           cfg_ready
);
  logic [DW-1:0] merged, new_q, mask_q;
  logic          expired, wd_clear, wd_run;

  reconf_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_rmw(req_rmw),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .prdy(cfg_ready), .prdata(cfg_rdata), .merged(merged), .expired(expired),
    .pe(cfg_en), .pwe(cfg_we), .paddr(cfg_addr), .pwdata(cfg_wdata),
    .busy(busy), .done(done), .timeout(timeout), .rdata(rdata),
    .new_q(new_q), .mask_q(mask_q), .wd_clear(wd_clear), .wd_run(wd_run)
  );

  reconf_merge #(.DW(DW)) u_merge (
    .old_val(cfg_rdata), .new_val(new_q), .mask(mask_q), .merged(merged)
  );

  reconf_watchdog #(.LIMIT(LIMIT)) u_wd (
    .clk(clk), .rst(rst), .clear(wd_clear), .run(wd_run), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) err_count <= '0;
    else if (req_valid && busy && !(&err_count)) err_count <= err_count + 1'b1;
  end

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy || !req_valid) |=> $stable(err_count));
  assert_err_saturate_R7: assert property (@(posedge clk) disable iff (rst)
    (&err_count) |=> (&err_count));
endmodule

// File: tb/reconf_port_master_test.sv
`timescale 1ns/1ps
module reconf_port_master_test;
  localparam int AW = 7, DW = 16, ECW = 8;
  localparam int ERRMAX = (1 << ECW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_rmw = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, req_mask = '0;
  logic busy, done, timeout, cfg_en, cfg_we;
  logic [DW-1:0] rdata, cfg_wdata;
  logic [ECW-1:0] err_count;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] s_rdata = '0;
  logic s_rdy = 1'b0;

  always #2 clk = ~clk;

  reconf_port_master uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_rmw(req_rmw), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .busy(busy), .done(done), .timeout(timeout),
    .rdata(rdata), .err_count(err_count), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(s_rdata),
    .cfg_ready(s_rdy)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slave
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int lat_cfg = 1, pend = 0;
  logic pend_we;
  logic [DW-1:0] rd_val;
  logic en_s = 0, we_s = 0;
  logic [AW-1:0] addr_s = '0;
  logic [DW-1:0] wd_s = '0;

  // model state
  int ph = 0, cnt = 0, m_err = 0;
  logic m_en = 0, m_we = 0, m_busy = 0, m_done = 0, m_to = 0, m_rmw = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rdata = '0, m_new = '0, m_mask = '0;
  bit started = 0;

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 16'h0101) ^ 16'h5A5A;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; cnt = 0; m_err = 0; m_en = 0; m_we = 0; m_busy = 0; m_done = 0;
      m_to = 0; m_rmw = 0; m_addr = '0; m_wd = '0; m_rdata = '0;
      started = 1;
      s_rdy <= 1'b0; pend = 0;
    end else begin
      m_en = 0; m_done = 0; m_to = 0;
      if (ph == 0) begin
        if (req_valid) begin
          m_en = 1; m_we = req_write && !req_rmw; m_addr = req_addr; m_wd = req_wdata;
          m_busy = 1; m_rmw = req_rmw; m_new = req_wdata; m_mask = req_mask;
          ph = m_we ? 2 : 1; cnt = 0;
        end
      end else begin
        if (req_valid && m_err < ERRMAX) m_err++;
        if (s_rdy) begin
          if (ph == 1) begin
            m_rdata = s_rdata;
            if (m_rmw) begin
              m_en = 1; m_we = 1; m_wd = (s_rdata & ~m_mask) | (m_new & m_mask);
              m_rmw = 0; ph = 2; cnt = 0;
            end else begin m_done = 1; m_busy = 0; ph = 0; end
          end else begin m_done = 1; m_busy = 0; ph = 0; end
        end else if (cnt == 255) begin
          m_done = 1; m_to = 1; m_busy = 0; ph = 0; m_rmw = 0;
        end else cnt++;
      end
      // slave response
      s_rdy <= 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin s_rdy <= 1'b1; if (!pend_we) s_rdata <= rd_val; end
      end
      if (en_s) begin
        if (we_s) mem[addr_s] = wd_s;
        rd_val = mem[addr_s]; pend_we = we_s;
        if (lat_cfg == 1) begin s_rdy <= 1'b1; if (!we_s) s_rdata <= mem[addr_s]; end
        else pend = lat_cfg - 1;
      end
    end
  end

  bit got_done = 0, got_to = 0;
  always @(negedge clk) begin
    en_s = cfg_en; we_s = cfg_we; addr_s = cfg_addr; wd_s = cfg_wdata;
    if (started && !rst) begin
      chk(cfg_en === m_en, "R2 enable", 32'(cfg_en), 32'(m_en));
      if (m_en) begin
        chk(cfg_we === m_we, "R4 write-enable", 32'(cfg_we), 32'(m_we));
        chk(cfg_addr === m_addr, "R2 address", 32'(cfg_addr), 32'(m_addr));
        chk(cfg_wdata === m_wd, "R5 write data", 32'(cfg_wdata), 32'(m_wd));
      end
      chk(busy === m_busy, "R6 busy", 32'(busy), 32'(m_busy));
      chk(done === m_done, "R3 done", 32'(done), 32'(m_done));
      chk(timeout === m_to, "R8 timeout", 32'(timeout), 32'(m_to));
      chk(rdata === m_rdata, "R3 rdata", 32'(rdata), 32'(m_rdata));
      chk(err_count === ECW'(m_err), "R7 err_count", 32'(err_count), 32'(m_err));
      if (done) got_done = 1;
      if (timeout) got_to = 1;
    end
  end

  task automatic issue(input bit w, input bit m, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [DW-1:0] k);
    @(negedge clk);
    req_valid = 1; req_write = w; req_rmw = m; req_addr = a; req_wdata = d; req_mask = k;
    got_done = 0;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (got_done) break;
    end
    chk(got_done, "R3 completion seen", 32'(got_done), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    chk(!cfg_en && !busy && !done && !timeout, "R1 control outputs", {cfg_en, busy, done, timeout}, 0);
    chk(rdata === '0 && err_count === '0, "R1 data outputs", {rdata, 8'h0, err_count}, 0);

    lat_cfg = 1; issue(1, 0, 7'd5, 16'h1234, 16'h0); wait_done();
    chk(mem[5] === 16'h1234, "R4 slave written", 32'(mem[5]), 32'h1234);
    lat_cfg = 3; issue(0, 0, 7'd5, 16'h0, 16'h0); wait_done();
    chk(rdata === 16'h1234, "R3 read value", 32'(rdata), 32'h1234);
    lat_cfg = 7; issue(1, 0, 7'h7F, 16'hFFFF, 16'h0); wait_done();
    lat_cfg = 2; issue(0, 0, 7'h7F, 16'h0, 16'h0); wait_done();
    chk(rdata === 16'hFFFF, "R9 all-ones read", 32'(rdata), 32'hFFFF);

    lat_cfg = 4; issue(0, 1, 7'd5, 16'hABCD, 16'h0FF0); wait_done();
    chk(mem[5] === 16'h1BC4, "R5 merged write", 32'(mem[5]), 32'h1BC4);
    chk(rdata === 16'h1234, "R5 old value returned", 32'(rdata), 32'h1234);
    lat_cfg = 1; issue(1, 1, 7'd5, 16'h0000, 16'hF000); wait_done();
    chk(mem[5] === 16'h0BC4, "R10 modify wins over write", 32'(mem[5]), 32'h0BC4);

    // R7: request held high across completions
    lat_cfg = 3;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_rmw = 0; req_addr = 7'd5;
    repeat (20) @(negedge clk);
    req_valid = 0;
    repeat (10) @(negedge clk);
    chk(err_count > 0, "R7 rejected requests counted", 32'(err_count), 32'd1);
    chk(!busy, "R6 idle after burst", 32'(busy), 32'd0);

    // R8: no ready within the window; R7 saturation during the wait
    lat_cfg = 300; got_to = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_rmw = 0; req_addr = 7'd9; got_done = 0;
    repeat (250) @(negedge clk);
    req_valid = 0;
    wait_done();
    chk(got_to, "R8 timeout flagged", 32'(got_to), 32'd1);
    repeat (60) @(negedge clk);
    chk(err_count === ECW'(ERRMAX), "R7 counter saturated", 32'(err_count), 32'(ERRMAX));
    chk(rdata === 16'h0BC4, "R8 late ready ignored", 32'(rdata), 32'h0BC4);
    lat_cfg = 2; issue(0, 0, 7'd5, 16'h0, 16'h0); wait_done();
    chk(rdata === 16'h0BC4, "R3 read after abort", 32'(rdata), 32'h0BC4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule